// File: doc/BRIEF.md
# Per-Channel Diagnosis Capture with General Fault Flag

This block sits behind the raw fault detectors of an eight-way low-side power switch. For every channel it watches three synchronized raw conditions: overload or overtemperature, open load and short to ground. A condition is reported only after it has been present for a programmable number of system clock cycles. The result is held as a two-bit code per channel, and the codes are packed into one diagnosis word that the serial interface shifts out. Whenever any channel holds a report, an active-low general fault output is pulled low, so a host can take an interrupt instead of polling.

Each channel runs a two-state machine. `CH_CLEAN` means nothing is reported. `CH_HELD` means a code has been captured. The transition *capture* (CLEAN to HELD) fires when any filtered condition qualifies. The transition *overwrite* (HELD to HELD with a new code) fires when a later condition qualifies on the same channel. The transition *wipe* (either state to CLEAN) fires when the serial block signals a valid completed frame, or when the reset-registers command pulses. A wipe also restarts every filter counter. A frame that the serial block judges invalid produces no pulse, so the word is kept.

Top module: `diag_capture`

## Requirements
- R1: After active-low reset every channel code is 2'b11, the diagnosis word is all ones, and `fault_n` is 1.
- R2: Channel k (counting from 1) occupies word bits [2k-1:2k-2]. The codes are 2'b11 for no fault, 2'b10 for overload/overtemperature, 2'b01 for open load and 2'b00 for short to ground.
- R3: A condition is captured only on the FILT_CYC-th consecutive rising clock edge at which it is present. If it drops earlier, nothing is reported and its count starts again from zero.
- R4: Open load and short to ground are counted only while the channel's `chan_on` bit is 0. While the channel is on, these inputs have no effect.
- R5: Overload/overtemperature is counted whatever the state of `chan_on`.
- R6: When several conditions qualify on one channel in the same cycle, the stored code follows this priority: overload first, then short to ground, then open load.
- R7: A condition that qualifies later on a channel that already holds a report replaces that channel's code.
- R8: `fault_n` is 0 exactly when at least one channel holds a code other than 2'b11.
- R9: A one-cycle pulse on `frame_valid` or `clear_cmd` returns every code to 2'b11 at that edge and restarts all filter counts. A condition that is still present is captured again FILT_CYC edges after the wipe.
- R10: When there is no wipe pulse, a captured code stays in place after its condition goes away.
- R11: Each channel's filtering and capture leave the codes of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_ovl | input | N_CH | Synchronized overload/overtemperature flags, one per channel |
| raw_open | input | N_CH | Synchronized open-load flags |
| raw_short | input | N_CH | Synchronized short-to-ground flags |
| chan_on | input | N_CH | Present on/off state of each output stage |
| frame_valid | input | 1 | One-cycle pulse at the end of a valid serial frame |
| clear_cmd | input | 1 | One-cycle pulse from the reset-registers command |
| diag_word | output | 2*N_CH | Packed two-bit codes, channel 1 in the lowest bits |
| fault_n | output | 1 | Active-low general fault flag |

## Verification
Several properties are checked on every cycle. A wipe pulse leaves the word all ones on the next cycle. The fault flag always agrees with the word. A code changes only in the cycle after a qualifying condition or a wipe. An overload capture always stores 2'b10. An open-load code can only appear after a cycle in which the channel was off. Only the directed scenarios can show the exact filter length, including a pulse one cycle too short and the restart of the count after a wipe. They also show that open and short inputs are ignored while the channel is on, that codes overwrite one another in order, and that the word is held when no wipe comes.

// File: rtl/diag_pkg.sv
package diag_pkg;
    typedef enum logic [1:0] {
        CODE_SHORT = 2'b00,
        CODE_OPEN  = 2'b01,
        CODE_OVL   = 2'b10,
        CODE_OK    = 2'b11
    } diag_code_e;

    typedef enum logic {
        CH_CLEAN = 1'b0,
        CH_HELD  = 1'b1
    } chan_state_e;
endpackage

// File: rtl/diag_filter.sv
module diag_filter #(
    parameter int FILT_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic cond,
    output logic qualify
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);
    localparam logic [CW-1:0] SAT  = CW'(FILT_CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart || !cond)
            cnt_q <= '0;
        else if (cnt_q != SAT)
            cnt_q <= cnt_q + 1'b1;
    end

    assign qualify = cond && !restart && (cnt_q == LAST);

    generate
        if (FILT_CYC > 1) begin : g_hist_chk
            AST_FILTER_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
                qualify |-> $past(cond)); // R3
        end
    endgenerate
endmodule

// File: rtl/diag_chan.sv
module diag_chan
    import diag_pkg::*;
#(
    parameter int FILT_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       chan_on,
    input  logic       raw_ovl,
    input  logic       raw_open,
    input  logic       raw_short,
    output diag_code_e code,
    output logic       held
);
    chan_state_e st_q, st_d;
    diag_code_e  code_q, code_d;
    logic q_ovl, q_open, q_short, any_q;

    diag_filter #(.FILT_CYC(FILT_CYC)) u_f_ovl (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .cond(raw_ovl), .qualify(q_ovl));

    diag_filter #(.FILT_CYC(FILT_CYC)) u_f_open (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .cond(raw_open & ~chan_on), .qualify(q_open));

    diag_filter #(.FILT_CYC(FILT_CYC)) u_f_short (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .cond(raw_short & ~chan_on), .qualify(q_short));

    assign any_q = q_ovl | q_open | q_short;

    function automatic diag_code_e pick_code(input logic o, input logic s);
        if (o)      return CODE_OVL;
        else if (s) return CODE_SHORT;
        else        return CODE_OPEN;
    endfunction

    always_comb begin
        st_d   = st_q;
        code_d = code_q;
        if (restart) begin
            st_d   = CH_CLEAN;
            code_d = CODE_OK;
        end else begin
            unique case (st_q)
                CH_CLEAN: if (any_q) begin
                    st_d   = CH_HELD;
                    code_d = pick_code(q_ovl, q_short);
                end
                CH_HELD: if (any_q) begin
                    code_d = pick_code(q_ovl, q_short);
                end
                default: st_d = CH_CLEAN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= CH_CLEAN;
            code_q <= CODE_OK;
        end else begin
            st_q   <= st_d;
            code_q <= code_d;
        end
    end

    always_comb begin
        held = (st_q == CH_HELD);
        code = (st_q == CH_HELD) ? code_q : CODE_OK;
    end

    AST_OVL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        q_ovl |=> (code_q == CODE_OVL)); // R6
    AST_CHANGE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_q) |-> $past(any_q || restart)); // R10
    AST_OPEN_ONLY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == CODE_OPEN && !$stable(code_q)) |-> !$past(chan_on)); // R4
endmodule

// File: rtl/diag_capture.sv
module diag_capture
    import diag_pkg::*;
#(
    parameter int N_CH     = 8,
    parameter int FILT_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   raw_ovl,
    input  logic [N_CH-1:0]   raw_open,
    input  logic [N_CH-1:0]   raw_short,
    input  logic [N_CH-1:0]   chan_on,
    input  logic              frame_valid,
    input  logic              clear_cmd,
    output logic [2*N_CH-1:0] diag_word,
    output logic              fault_n
);
    localparam int WORD_W = 2 * N_CH;

    logic            wipe;
    logic [N_CH-1:0] held;

    assign wipe = frame_valid | clear_cmd;

    generate
        for (genvar k = 0; k < N_CH; k++) begin : g_ch
            diag_code_e code_k;
            diag_chan #(.FILT_CYC(FILT_CYC)) u_chan (
                .clk(clk), .rst_n(rst_n), .restart(wipe),
                .chan_on(chan_on[k]), .raw_ovl(raw_ovl[k]),
                .raw_open(raw_open[k]), .raw_short(raw_short[k]),
                .code(code_k), .held(held[k]));
            assign diag_word[2*k+1:2*k] = code_k;
        end
    endgenerate

    assign fault_n = ~|held;

    AST_WIPE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (diag_word == {WORD_W{1'b1}})); // R9
    AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        fault_n == (diag_word == {WORD_W{1'b1}})); // R8
endmodule

// File: tb/diag_capture_bench.sv
module diag_capture_bench;
    localparam int N  = 8;
    localparam int FT = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  raw_ovl = '0, raw_open = '0, raw_short = '0;
    logic [N-1:0]  chan_on = '1;
    logic          frame_valid = 1'b0, clear_cmd = 1'b0;
    logic [2*N-1:0] diag_word;
    logic          fault_n;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    diag_capture #(.N_CH(N), .FILT_CYC(FT)) u_diag_capture (
        .clk(clk), .rst_n(rst_n), .raw_ovl(raw_ovl), .raw_open(raw_open),
        .raw_short(raw_short), .chan_on(chan_on), .frame_valid(frame_valid),
        .clear_cmd(clear_cmd), .diag_word(diag_word), .fault_n(fault_n));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wipe_all();
        raw_ovl = '0; raw_open = '0; raw_short = '0; chan_on = '1;
        clear_cmd = 1'b1; tick(1); clear_cmd = 1'b0;
        chk("R9 clear_cmd wipe", diag_word, 16'hFFFF);
    endtask

    task automatic t_reset();
        tick(2); rst_n = 1'b1; tick(1);
        chk("R1 word", diag_word, 16'hFFFF);
        chk("R1 flag", {15'b0, fault_n}, 16'h0001);
    endtask

    task automatic t_filter();
        raw_ovl[0] = 1'b1; tick(FT - 1); raw_ovl[0] = 1'b0; tick(1);
        chk("R3 short pulse ignored", diag_word, 16'hFFFF);
        raw_ovl[0] = 1'b1; tick(FT - 1);
        chk("R3 count restarted", diag_word, 16'hFFFF);
        tick(1);
        chk("R5 R2 R11 ovl while on", diag_word, 16'hFFFE);
        chk("R8 flag low", {15'b0, fault_n}, 16'h0000);
        raw_ovl[0] = 1'b0; tick(20);
        chk("R10 held without wipe", diag_word, 16'hFFFE);
        frame_valid = 1'b1; tick(1); frame_valid = 1'b0;
        chk("R9 frame wipe", diag_word, 16'hFFFF);
        chk("R8 flag high", {15'b0, fault_n}, 16'h0001);
    endtask

    task automatic t_offstate();
        raw_open[1] = 1'b1; raw_short[4] = 1'b1; tick(20);
        chk("R4 ignored while on", diag_word, 16'hFFFF);
        chan_on[1] = 1'b0; tick(FT - 1);
        chk("R4 R3 filtering", diag_word, 16'hFFFF);
        tick(1);
        chk("R2 open code ch2", diag_word, 16'hFFF7);
        chan_on[4] = 1'b0; tick(FT);
        chk("R2 R11 short code ch5", diag_word, 16'hFCF7);
        clear_cmd = 1'b1; tick(1); clear_cmd = 1'b0;
        chk("R9 wipe while present", diag_word, 16'hFFFF);
        tick(FT - 1);
        chk("R9 timer restarted", diag_word, 16'hFFFF);
        tick(1);
        chk("R9 recapture", diag_word, 16'hFCF7);
        wipe_all();
    endtask

    task automatic t_priority();
        chan_on[5] = 1'b0;
        raw_ovl[5] = 1'b1; raw_open[5] = 1'b1; raw_short[5] = 1'b1;
        tick(FT);
        chk("R6 ovl beats others", diag_word, 16'hFBFF);
        raw_ovl[5] = 1'b0; tick(4);
        chk("R6 R10 kept", diag_word, 16'hFBFF);
        wipe_all();
        chan_on[5] = 1'b0; raw_open[5] = 1'b1; raw_short[5] = 1'b1;
        tick(FT);
        chk("R6 short beats open", diag_word, 16'hF3FF);
        wipe_all();
    endtask

    task automatic t_overwrite();
        chan_on[7] = 1'b0; raw_open[7] = 1'b1; tick(FT);
        chk("R7 first open", diag_word, 16'h7FFF);
        raw_short[7] = 1'b1; tick(FT);
        chk("R7 short overwrites", diag_word, 16'h3FFF);
        raw_ovl[7] = 1'b1; tick(FT);
        chk("R7 ovl overwrites", diag_word, 16'hBFFF);
        wipe_all();
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_filter();
        t_offstate();
        t_priority();
        t_overwrite();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule